// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block collects interrupt requests for a small computer's custom chipset and turns them into one 3-bit interrupt level for the CPU. It holds two 15-bit registers: an enable register and a request register. The CPU reads and modifies both over a simple register bus. Bit 14 of the enable register is a master switch. The video timing logic sends a single-cycle vertical-blank pulse once per frame, when the beam wraps back to its first line.

Writes never overwrite a register. Bit 15 of the write data picks the operation. When it is 1, every other 1-bit is set in the register. When it is 0, every other 1-bit is cleared. Bits written as 0 are left as they were. This lets several pieces of software manage their own bits without a read-modify-write.

The requests that are both pending and enabled are grouped by source into levels 6 down to 1. The highest group with an active bit gives the level. That level is held in a register and presented to the CPU.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the level output is 0 and both registers read back as 0x0000.
- R2: A write with data bit 15 at 1 sets bits 14:0 of the target register wherever the data holds a 1. Bits where the data holds a 0 are unchanged. The enable register is written at offset 0x09A and the request register at 0x09C.
- R3: A write with data bit 15 at 0 clears bits 14:0 of the target register wherever the data holds a 1. All other bits are unchanged.
- R4: A read at offset 0x01C returns the enable register and a read at 0x01E returns the request register, in the same cycle. Bit 15 always reads as 0. When the read strobe is low, or the offset is any other value, the read data is 0x0000.
- R5: A vertical-blank pulse sets request bit 5.
- R6: If a vertical-blank pulse and a CPU clear of request bit 5 happen in the same cycle, bit 5 ends up set.
- R7: The level is 0 whenever enable bit 14 is clear, whatever requests are pending.
- R8: The level is decided only by bits 13:0 of (enable AND request), with the highest rule that matches winning:
  - bit 13 gives level 6;
  - bits 11 or 12 give level 5;
  - bits 7 to 10 give level 4;
  - bits 4 to 6 give level 3;
  - bits 0 to 2 give level 1;
  - nothing active gives level 0.
- R9: Bit 3 on its own gives level 0, and the level output never takes the value 2.
- R10: The level output is registered. It reflects a register change one clock after the edge that made the change.
- R11: Writes to any offset other than 0x09A and 0x09C change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_rdata | output | 16 | Read data (combinational) |
| vblank_pulse | input | 1 | One-cycle vertical-blank strobe from the video timing logic |
| irq_level | output | 3 | Registered CPU interrupt level, 0 to 6 |

## Verification
The hardest case to reach from the ports is the same-cycle race: a vertical-blank pulse arriving on exactly the edge where the CPU clears bit 5. The bench drives both strobes in one directed cycle and then reads the request register back. A random phase then mixes pulses with writes of both kinds at a rate that produces many more such collisions. A behavioural model predicts both registers and the level on every clock. The per-bit walk covers each request source alone, including bit 3, which must not raise the level.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned REG_W      = 16;
   localparam int unsigned STORE_W    = 15;
   localparam int unsigned NUM_SRC    = 14;
   localparam int unsigned OP_BIT     = 15;
   localparam int unsigned MASTER_BIT = 14;
   localparam int unsigned VBL_BIT    = 5;
   localparam int unsigned LVL_W      = 3;
   localparam int unsigned NUM_LVL    = 7;

   // Request sources feeding each CPU level; level 2 has no source.
   function automatic logic [NUM_SRC-1:0] level_mask(input int unsigned lvl);
      logic [NUM_SRC-1:0] m;
      m = '0;
      case (lvl)
         6: m[13]    = 1'b1;
         5: m[12:11] = 2'b11;
         4: m[10:7]  = 4'hF;
         3: m[6:4]   = 3'b111;
         1: m[2:0]   = 3'b111;
         default: m  = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned OFF_EWR = 'h09A,
   parameter int unsigned OFF_RWR = 'h09C,
   parameter int unsigned OFF_ERD = 'h01C,
   parameter int unsigned OFF_RRD = 'h01E
) (
   input  logic              bus_we,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              en_wr,
   output logic              req_wr,
   output logic              en_sel,
   output logic              req_sel
);
   if (OFF_EWR >= (1 << ADDR_W) || OFF_RWR >= (1 << ADDR_W) ||
       OFF_ERD >= (1 << ADDR_W) || OFF_RRD >= (1 << ADDR_W)) begin : g_off_chk
      $error("irq_bus_decode: register offset does not fit ADDR_W");
   end

   localparam logic [ADDR_W-1:0] A_EWR = ADDR_W'(OFF_EWR);
   localparam logic [ADDR_W-1:0] A_RWR = ADDR_W'(OFF_RWR);
   localparam logic [ADDR_W-1:0] A_ERD = ADDR_W'(OFF_ERD);
   localparam logic [ADDR_W-1:0] A_RRD = ADDR_W'(OFF_RRD);

   always_comb begin
      en_wr   = bus_we && (bus_addr == A_EWR);
      req_wr  = bus_we && (bus_addr == A_RWR);
      en_sel  = bus_rd && (bus_addr == A_ERD);
      req_sel = bus_rd && (bus_addr == A_RRD);
   end
endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
   parameter int unsigned W     = 15,
   parameter int unsigned OP_IX = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [OP_IX:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   if (W > OP_IX) begin : g_w_chk
      $error("irq_setclr_reg: stored width must sit below the op bit");
   end

   logic [W-1:0] nxt;

   // Hardware set is ORed in last so it overrides a CPU clear.
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         nxt[i] = q[i];
         if (wr && wdata[i]) nxt[i] = wdata[OP_IX];
         nxt[i] = nxt[i] | hw_set[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import irq_pkg::*;
#(
   parameter int unsigned SRC_N = irq_pkg::NUM_SRC,
   parameter int unsigned LW    = irq_pkg::LVL_W,
   parameter int unsigned LVLS  = irq_pkg::NUM_LVL
) (
   input  logic [SRC_N-1:0] active,
   input  logic             master,
   output logic [LW-1:0]    level
);
   if (SRC_N != NUM_SRC) begin : g_src_chk
      $error("irq_prio_enc: source count must match the level map");
   end
   if (LVLS > (1 << LW)) begin : g_lw_chk
      $error("irq_prio_enc: LW too narrow for LVLS");
   end

   logic [LVLS-1:1] hit;

   for (genvar l = 1; l < LVLS; l++) begin : g_lvl
      assign hit[l] = |(active & level_mask(l));
   end

   always_comb begin
      level = '0;
      if (master) begin
         for (int l = 1; l < int'(LVLS); l++) begin
            if (hit[l]) level = LW'(l);
         end
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned OFF_EWR = 'h09A,
   parameter int unsigned OFF_RWR = 'h09C,
   parameter int unsigned OFF_ERD = 'h01C,
   parameter int unsigned OFF_RRD = 'h01E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              vblank_pulse,
   output logic [2:0]        irq_level
);
   if (REG_W != 16 || LVL_W != 3) begin : g_pkg_chk
      $error("irq_prio_ctrl: port widths assume 16-bit data, 3-bit level");
   end

   logic en_wr, req_wr, en_sel, req_sel;
   logic [STORE_W-1:0] en_q, req_q, hw_req, hw_en;
   logic [LVL_W-1:0]   lvl_c;

   irq_bus_decode #(
      .ADDR_W(ADDR_W), .OFF_EWR(OFF_EWR), .OFF_RWR(OFF_RWR),
      .OFF_ERD(OFF_ERD), .OFF_RRD(OFF_RRD)
   ) u_dec (
      .bus_we(bus_we), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .en_wr(en_wr), .req_wr(req_wr), .en_sel(en_sel), .req_sel(req_sel)
   );

   always_comb begin
      hw_en  = '0;
      hw_req = '0;
      hw_req[VBL_BIT] = vblank_pulse;
   end

   irq_setclr_reg #(.W(STORE_W), .OP_IX(OP_BIT)) u_en (
      .clk(clk), .rst_n(rst_n), .wr(en_wr), .wdata(bus_wdata),
      .hw_set(hw_en), .q(en_q)
   );

   irq_setclr_reg #(.W(STORE_W), .OP_IX(OP_BIT)) u_req (
      .clk(clk), .rst_n(rst_n), .wr(req_wr), .wdata(bus_wdata),
      .hw_set(hw_req), .q(req_q)
   );

   irq_prio_enc u_enc (
      .active(en_q[NUM_SRC-1:0] & req_q[NUM_SRC-1:0]),
      .master(en_q[MASTER_BIT]),
      .level(lvl_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_level <= '0;
      else        irq_level <= lvl_c;
   end

   always_comb begin
      bus_rdata = '0;
      if (en_sel)  bus_rdata = {1'b0, en_q};
      if (req_sel) bus_rdata = {1'b0, req_q};
   end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       bus_wdata,
   input logic              vblank_pulse,
   input logic [2:0]        irq_level,
   input logic [14:0]       en_q,
   input logic [14:0]       req_q
);
   // R9
   level_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != 3'd2) && (irq_level != 3'd7));

   // R7
   master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[14] |=> (irq_level == 3'd0));

   // R8
   top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[14] && en_q[13] && req_q[13]) |=> (irq_level == 3'd6));

   // R5
   vblank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_pulse |=> req_q[5]);

   // R2
   req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'('h09C) && bus_wdata[15])
      |=> ((req_q & $past(bus_wdata[14:0])) == $past(bus_wdata[14:0])));

   // R3
   req_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'('h09C) && !bus_wdata[15] && !vblank_pulse)
      |=> ((req_q & $past(bus_wdata[14:0])) == 15'd0));

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_we && bus_addr == ADDR_W'('h09C)) && !vblank_pulse) |=> $stable(req_q));

   // R11
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == ADDR_W'('h09A)) |=> $stable(en_q));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .vblank_pulse(vblank_pulse),
   .irq_level(irq_level), .en_q(en_q), .req_q(req_q)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
   localparam int A_EWR = 'h09A, A_RWR = 'h09C, A_ERD = 'h01C, A_RRD = 'h01E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_rd = 1'b0, vblank_pulse = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  irq_level;

   int checks = 0, fails = 0;
   int m_en = 0, m_req = 0, m_lvl = 0;
   bit done = 0;

   always #2 clk = ~clk;

   irq_prio_ctrl u_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .vblank_pulse(vblank_pulse), .irq_level(irq_level)
   );

   function automatic int lvl_of(int en, int rq);
      int a;
      a = en & rq & 'h3FFF;
      if (((en >> 14) & 1) == 0 || a == 0) return 0;
      if (a & 'h2000) return 6;
      if (a & 'h1800) return 5;
      if (a & 'h0780) return 4;
      if (a & 'h0070) return 3;
      if (a & 'h0007) return 1;
      return 0;
   endfunction

   function automatic int apply(int r, int d);
      if (d & 'h8000) return r | (d & 'h7FFF);
      return r & ~(d & 'h7FFF) & 'h7FFF;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Reference model, updated on each edge from the inputs driven at the prior falling edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_req = 0; m_lvl = 0;
      end else begin
         m_lvl = lvl_of(m_en, m_req);
         if (bus_we && bus_addr == 9'(A_EWR)) m_en  = apply(m_en, bus_wdata);
         if (bus_we && bus_addr == 9'(A_RWR)) m_req = apply(m_req, bus_wdata);
         if (vblank_pulse) m_req = m_req | 'h20;
      end
   end

   // Per-cycle comparison against the model, away from the rising edge.
   always @(negedge clk) begin
      int exp_rd;
      #1;
      if (rst_n) begin
         exp_rd = 0;
         if (bus_rd && bus_addr == 9'(A_ERD)) exp_rd = m_en;
         if (bus_rd && bus_addr == 9'(A_RRD)) exp_rd = m_req;
         chk(int'(irq_level) == m_lvl, "R10 level vs model", int'(irq_level), m_lvl);
         chk(int'(bus_rdata) == exp_rd, "R4 readback vs model", int'(bus_rdata), exp_rd);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 9'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 9'(a);
      #1 v = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic settle_lvl(input int exp, input string tag);
      @(negedge clk); #1;
      chk(int'(irq_level) == exp, tag, int'(irq_level), exp);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int v, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(irq_level == 3'd0, "R1 level", int'(irq_level), 0);
      rd(A_ERD, v); chk(v == 0, "R1 enable", v, 0);
      rd(A_RRD, v); chk(v == 0, "R1 request", v, 0);

      // R7: all sources enabled but master off
      wr(A_EWR, 'hBFFF);
      wr(A_RWR, 'hA000);
      settle_lvl(0, "R7 master off");
      rd(A_ERD, v); chk(v == 'h3FFF, "R2 enable set", v, 'h3FFF);

      // R10: master on, one cycle of latency
      wr(A_EWR, 'hC000);
      #1 chk(irq_level == 3'd0, "R10 level before update", int'(irq_level), 0);
      settle_lvl(6, "R8 external -> 6");

      wr(A_RWR, 'h7FFF);
      rd(A_RRD, v); chk(v == 0, "R3 clear all", v, 0);
      settle_lvl(0, "R3 level after clear");

      // Walk each source alone
      for (int b = 0; b < 14; b++) begin
         if (b == 13) e = 6;
         else if (b >= 11) e = 5;
         else if (b >= 7) e = 4;
         else if (b >= 4) e = 3;
         else if (b == 3) e = 0;
         else e = 1;
         wr(A_RWR, 'h8000 | (1 << b));
         settle_lvl(e, (b == 3) ? "R9 bit3 alone" : "R8 single source");
         wr(A_RWR, 1 << b);
      end

      // Priority fall-through
      wr(A_RWR, 'h8111);
      settle_lvl(4, "R8 mix 0,4,8");
      wr(A_RWR, 'h0100);
      settle_lvl(3, "R8 after audio cleared");
      wr(A_RWR, 'h0001);
      rd(A_RRD, v); chk(v == 'h0010, "R3 other bits unchanged", v, 'h0010);
      wr(A_RWR, 'h7FFF);

      // R5 vertical blank
      @(negedge clk); vblank_pulse = 1'b1;
      @(negedge clk); vblank_pulse = 1'b0;
      rd(A_RRD, v); chk(v == 'h0020, "R5 vblank sets bit5", v, 'h0020);
      settle_lvl(3, "R8 vblank -> 3");

      // R6 collision: clear bit5 and pulse together
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 9'(A_RWR); bus_wdata = 16'h0020; vblank_pulse = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; vblank_pulse = 1'b0;
      rd(A_RRD, v); chk(v == 'h0020, "R6 hardware set wins", v, 'h0020);

      // R4 bit 15 reads 0, unmapped read gives 0
      wr(A_RWR, 'hFFFF);
      rd(A_RRD, v); chk(v == 'h7FFF, "R4 bit15 reads 0", v, 'h7FFF);
      rd('h09E, v); chk(v == 0, "R4 unmapped read", v, 0);

      // R11 writes elsewhere ignored
      wr('h09E, 'h7FFF);
      wr(A_ERD, 'h7FFF);
      wr(A_RRD, 'h7FFF);
      rd(A_ERD, v); chk(v == 'h7FFF, "R11 enable untouched", v, 'h7FFF);
      rd(A_RRD, v); chk(v == 'h7FFF, "R11 request untouched", v, 'h7FFF);

      // R7 master clear drops level
      wr(A_EWR, 'h4000);
      settle_lvl(0, "R7 master cleared");

      // Random traffic, checked every cycle by the model
      for (int i = 0; i < 4000; i++) begin
         int sel;
         @(negedge clk);
         sel = int'($urandom_range(0, 5));
         bus_we = $urandom_range(0, 1) == 1;
         bus_rd = $urandom_range(0, 1) == 1;
         case (sel)
            0: bus_addr = 9'(A_EWR);
            1, 2: bus_addr = 9'(A_RWR);
            3: bus_addr = 9'(A_ERD);
            4: bus_addr = 9'(A_RRD);
            default: bus_addr = 9'($urandom_range(0, 511));
         endcase
         bus_wdata = 16'($urandom);
         vblank_pulse = $urandom_range(0, 7) == 0;
      end
      @(negedge clk);
      bus_we = 1'b0; bus_rd = 1'b0; vblank_pulse = 1'b0;
      repeat (3) @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule